// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Reader

This block fetches a run of consecutive bytes from a serial EEPROM that is reached through one control word made of four bits: two chip-access bits (one active high, one active low), a serial clock and a data-out line, plus a data-in line returned by the memory. A client raises a start request together with a 16-bit byte offset and a byte count. The block then opens the access session, shifts out the read opcode followed by the two offset bytes, and clocks in the requested number of bytes.

Every control-word change is held for a parameterised number of system clocks, so that a slow EEPROM sees clean, wide phases. Each received byte appears on a valid/ready stream. While the consumer withholds ready, the serial clock stays low and no further bits are fetched. When the last byte has been taken, or immediately after the address when the count is zero, the block closes the session. It then pulses done and drops busy.

Top module: `serial_rom_reader`

## Requirements
- R1: At rest the access-high bit is 0 and the access-low bit is 1. A session opens by first raising access-high and then, one phase later, clearing access-low.
- R2: Every session ends by first raising access-low and then, one phase later, clearing access-high. done pulses for one cycle only after both bits are back at rest.
- R3: For each bit sent, data-out is placed while the serial clock is low. The clock then rises and later falls, and data-out does not change while the clock is high or on the cycle it rises.
- R4: For each bit received, the clock rises, data-in is sampled at the end of the high phase, and the clock falls. No data-out setup phase comes before it.
- R5: Bytes travel most significant bit first in both directions. A received byte is formed by shifting left and placing the new bit in bit 0.
- R6: A session sends opcode 0x03, then offset bits 15:8, then offset bits 7:0. It then clocks in exactly count bytes, taken from consecutive addresses starting at the offset.
- R7: Every clock-high phase, and every access-bit phase, lasts exactly PH_CYC system clocks.
- R8: busy rises on the cycle after an accepted start and stays high until done. A start while busy is ignored and leaves the running session unchanged.
- R9: A count of zero performs the open, opcode and address phases, then closes with no data clocks and no stream output.
- R10: A received byte stays on byte_data_o with byte_valid_o high until byte_ready_i is seen. Throughout that wait the serial clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| offset_i | input | 16 | First byte address to read |
| count_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse after access is released |
| rom_acc_hi_o | output | 1 | Chip-access bit, active high |
| rom_acc_lo_o | output | 1 | Chip-access bit, active low |
| rom_sck_o | output | 1 | Serial clock to the EEPROM |
| rom_mosi_o | output | 1 | Serial data to the EEPROM |
| rom_miso_i | input | 1 | Serial data from the EEPROM |
| byte_valid_o | output | 1 | Received byte available |
| byte_data_o | output | 8 | Received byte |
| byte_ready_i | input | 1 | Consumer accepts the byte |

## Verification
The assertions check the following on every cycle: the ordering of the two access bits at each edge, that the serial clock moves only inside an open session, the stability of data-out around the clock-high phase, the exact high-phase width, clock-low stalls while a byte waits, and the busy/done relationship. Other properties only show in the bench scenarios against an EEPROM model: the opcode and address bit order, the bytes returned from consecutive addresses (including wrap at the top of the address space), the total clock count of a zero-length read, and the fact that a second start during a session changes nothing.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_OPEN_HI, SQ_OPEN_LO, SQ_HDR, SQ_RD, SQ_HOLD, SQ_CLOSE_LO, SQ_CLOSE_HI
  } seq_state_t;

  typedef enum logic [1:0] {
    BE_IDLE, BE_SETUP, BE_HIGH, BE_LOW
  } bit_state_t;

  localparam logic [7:0] ROM_READ_OP = 8'h03;
endpackage

// File: rtl/srr_phase_timer.sv
module srr_phase_timer #(
  parameter int PH_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int TW = (PH_CYC < 2) ? 1 : $clog2(PH_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(PH_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);
endmodule

// File: rtl/srr_byte_engine.sv
module srr_byte_engine
  import srr_pkg::*;
#(
  parameter int PH_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       dir_out,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       fin
);
  bit_state_t st;
  logic [7:0] shreg;
  logic [2:0] nbit;
  logic       is_out;
  logic       t_exp;
  logic       t_clr;

  // restart the phase timer whenever the engine changes phase
  assign t_clr = (st == BE_IDLE) || t_exp;

  srr_phase_timer #(.PH_CYC(PH_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clr(t_clr), .expired(t_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= BE_IDLE;
      shreg  <= '0;
      nbit   <= '0;
      is_out <= 1'b0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        BE_IDLE: if (go) begin
          nbit   <= '0;
          is_out <= dir_out;
          if (dir_out) begin
            shreg <= tx_byte;
            mosi  <= tx_byte[7];
            st    <= BE_SETUP;
          end else begin
            shreg <= '0;
            sck   <= 1'b1;
            st    <= BE_HIGH;
          end
        end
        BE_SETUP: if (t_exp) begin
          sck <= 1'b1;
          st  <= BE_HIGH;
        end
        BE_HIGH: if (t_exp) begin
          sck <= 1'b0;
          st  <= BE_LOW;
          if (!is_out) shreg <= {shreg[6:0], miso};
        end
        BE_LOW: if (t_exp) begin
          nbit <= nbit + 1'b1;
          if (nbit == 3'd7) begin
            fin <= 1'b1;
            st  <= BE_IDLE;
          end else if (is_out) begin
            shreg <= {shreg[6:0], 1'b0};
            mosi  <= shreg[6];
            st    <= BE_SETUP;
          end else begin
            sck <= 1'b1;
            st  <= BE_HIGH;
          end
        end
        default: st <= BE_IDLE;
      endcase
    end
  end

  assign rx_byte = shreg;
endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
  import srr_pkg::*;
#(
  parameter int PH_CYC = 4,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [15:0]      offset_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             rom_acc_hi_o,
  output logic             rom_acc_lo_o,
  output logic             rom_sck_o,
  output logic             rom_mosi_o,
  input  logic             rom_miso_i,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  input  logic             byte_ready_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_t       st;
  logic [15:0]      off_q;
  logic [CNT_W-1:0] remain;
  logic [1:0]       hdr_idx;
  logic             eng_go;
  logic             eng_dir;
  logic [7:0]       eng_tx;
  logic [7:0]       eng_rx;
  logic             eng_fin;
  logic             t_exp;
  logic             t_clr;
  logic             timed;

  assign timed = (st == SQ_OPEN_HI) || (st == SQ_OPEN_LO) ||
                 (st == SQ_CLOSE_LO) || (st == SQ_CLOSE_HI);
  assign t_clr = !timed || t_exp;

  srr_phase_timer #(.PH_CYC(PH_CYC)) u_acc_tmr (
    .clk(clk), .rst(rst), .clr(t_clr), .expired(t_exp)
  );

  srr_byte_engine #(.PH_CYC(PH_CYC)) u_engine (
    .clk(clk), .rst(rst), .go(eng_go), .dir_out(eng_dir), .tx_byte(eng_tx),
    .miso(rom_miso_i), .sck(rom_sck_o), .mosi(rom_mosi_o),
    .rx_byte(eng_rx), .fin(eng_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= SQ_IDLE;
      off_q        <= '0;
      remain       <= '0;
      hdr_idx      <= '0;
      eng_go       <= 1'b0;
      eng_dir      <= 1'b0;
      eng_tx       <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      rom_acc_hi_o <= 1'b0;
      rom_acc_lo_o <= 1'b1;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
    end else begin
      done_o <= 1'b0;
      eng_go <= 1'b0;
      case (st)
        SQ_IDLE: if (start_i) begin
          busy_o       <= 1'b1;
          rom_acc_hi_o <= 1'b1;
          off_q        <= offset_i;
          remain       <= count_i;
          st           <= SQ_OPEN_HI;
        end
        SQ_OPEN_HI: if (t_exp) begin
          rom_acc_lo_o <= 1'b0;
          st           <= SQ_OPEN_LO;
        end
        SQ_OPEN_LO: if (t_exp) begin
          eng_go  <= 1'b1;
          eng_dir <= 1'b1;
          eng_tx  <= ROM_READ_OP;
          hdr_idx <= '0;
          st      <= SQ_HDR;
        end
        SQ_HDR: if (eng_fin) begin
          if (hdr_idx == 2'd2) begin
            if (remain == '0) begin
              rom_acc_lo_o <= 1'b1;
              st           <= SQ_CLOSE_LO;
            end else begin
              eng_go  <= 1'b1;
              eng_dir <= 1'b0;
              st      <= SQ_RD;
            end
          end else begin
            hdr_idx <= hdr_idx + 1'b1;
            eng_go  <= 1'b1;
            eng_tx  <= (hdr_idx == 2'd0) ? off_q[15:8] : off_q[7:0];
          end
        end
        SQ_RD: if (eng_fin) begin
          byte_valid_o <= 1'b1;
          byte_data_o  <= eng_rx;
          st           <= SQ_HOLD;
        end
        SQ_HOLD: if (byte_ready_i) begin
          byte_valid_o <= 1'b0;
          remain       <= remain - 1'b1;
          if (remain == ONE) begin
            rom_acc_lo_o <= 1'b1;
            st           <= SQ_CLOSE_LO;
          end else begin
            eng_go <= 1'b1;
            st     <= SQ_RD;
          end
        end
        SQ_CLOSE_LO: if (t_exp) begin
          rom_acc_hi_o <= 1'b0;
          st           <= SQ_CLOSE_HI;
        end
        SQ_CLOSE_HI: if (t_exp) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int PH_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       rom_acc_hi_o,
  input logic       rom_acc_lo_o,
  input logic       rom_sck_o,
  input logic       rom_mosi_o,
  input logic       byte_valid_o,
  input logic [7:0] byte_data_o,
  input logic       byte_ready_i
);
  localparam int HW = $clog2(PH_CYC + 2);
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) hcnt <= '0;
    else if (rom_sck_o) hcnt <= hcnt + 1'b1;
    else hcnt <= '0;
  end

  AST_OPEN_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_acc_hi_o) |-> rom_acc_lo_o); // R1
  AST_OPEN_LO_SECOND: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_acc_lo_o) |-> rom_acc_hi_o); // R1
  AST_CLOSE_LO_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_acc_lo_o) |-> rom_acc_hi_o); // R2
  AST_CLOSE_HI_SECOND: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_acc_hi_o) |-> rom_acc_lo_o); // R2
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!rom_acc_hi_o && rom_acc_lo_o && !busy_o)); // R2
  AST_SCK_IN_SESSION: assert property (@(posedge clk) disable iff (rst)
    rom_sck_o |-> (rom_acc_hi_o && !rom_acc_lo_o)); // R3
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    rom_sck_o |-> $stable(rom_mosi_o)); // R3
  AST_SCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_sck_o) |-> (hcnt == HW'(PH_CYC))); // R7
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R8
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o); // R8
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o))); // R10
  AST_STALL_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> !rom_sck_o); // R10
endmodule

bind serial_rom_reader srr_checker #(.PH_CYC(PH_CYC)) u_srr_checker (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .rom_acc_hi_o(rom_acc_hi_o), .rom_acc_lo_o(rom_acc_lo_o),
  .rom_sck_o(rom_sck_o), .rom_mosi_o(rom_mosi_o),
  .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
  .byte_ready_i(byte_ready_i)
);

// File: tb/serial_rom_reader_test.sv
`timescale 1ns/1ps
module serial_rom_reader_test;
  localparam int PH = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   off_in = '0;
  logic [CW-1:0] cnt_in = '0;
  logic          busy, done, acc_hi, acc_lo, sck, mosi, valid;
  logic          miso;
  logic [7:0]    data;
  logic          ready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  serial_rom_reader #(.PH_CYC(PH), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start_i(start), .offset_i(off_in), .count_i(cnt_in),
    .busy_o(busy), .done_o(done), .rom_acc_hi_o(acc_hi), .rom_acc_lo_o(acc_lo),
    .rom_sck_o(sck), .rom_mosi_o(mosi), .rom_miso_i(miso),
    .byte_valid_o(valid), .byte_data_o(data), .byte_ready_i(ready)
  );

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  // ---------------- EEPROM model ----------------
  int          bitcnt = 0;
  int          total_bits = 0;
  logic [23:0] shin = '0;

  always @(negedge sck or posedge acc_lo) begin
    if (acc_lo) bitcnt <= 0;
    else        bitcnt <= bitcnt + 1;
  end
  always @(negedge sck) total_bits <= total_bits + 1;
  always @(posedge sck) if (bitcnt < 24) shin <= {shin[22:0], mosi};

  always @* begin
    int dp;
    logic [7:0] b;
    miso = 1'b0;
    if (bitcnt >= 24) begin
      dp   = bitcnt - 24;
      b    = rom_fn(shin[15:0] + 16'(dp / 8));
      miso = b[7 - (dp % 8)];
    end
  end

  // ---------------- check helper ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  int rcv_cnt = 0;
  int hi_run = 0;
  int last_hi = 0;
  bit stall_mode = 1'b0;

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (sck) hi_run++;
        else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
        if (valid && !ready) chk(!sck, "R10 sck low while stalled", sck, 0);
        if (valid && ready) begin
          rcv_cnt++;
          if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", data, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(data == e, "R4/R5 byte value", data, e);
          end
        end
      end
    end
  end

  initial begin : ready_drv
    logic [7:0] lf;
    lf = 8'h5B;
    forever begin
      @(posedge clk);
      #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      ready = stall_mode ? lf[0] : 1'b1;
    end
  end

  task automatic run_read(input logic [15:0] off, input int n, input bit poke);
    int bits0, rcv0;
    for (int i = 0; i < n; i++) exp_q.push_back(rom_fn(off + 16'(i)));
    bits0 = total_bits;
    rcv0  = rcv_cnt;
    @(posedge clk); #1;
    start = 1'b1; off_in = off; cnt_in = CW'(n);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    chk(acc_hi && acc_lo, "R1 access-high raised before access-low cleared",
        {acc_hi, acc_lo}, 3);
    repeat (PH) @(negedge clk);
    chk(acc_hi && !acc_lo, "R1 session open", {acc_hi, acc_lo}, 2);
    if (poke) begin
      repeat (40) @(posedge clk); #1;
      start = 1'b1; off_in = ~off; cnt_in = CW'(2);
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(!acc_hi && acc_lo, "R2 access released at done", {acc_hi, acc_lo}, 1);
    chk(!busy, "R8 busy low at done", busy, 0);
    chk(shin[23:16] == 8'h03, "R6 opcode", shin[23:16], 8'h03);
    chk(shin[15:0] == off, "R5/R6 offset sent msb first", shin[15:0], off);
    chk(total_bits - bits0 == 24 + 8 * n,
        (n == 0) ? "R9 clock count for zero length" : "R6 clock count",
        total_bits - bits0, 24 + 8 * n);
    chk(rcv_cnt - rcv0 == n, "R6 bytes delivered", rcv_cnt - rcv0, n);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    chk(last_hi == PH, "R7 clock high width", last_hi, PH);
    repeat (20) @(negedge clk);
    chk(!busy && !sck && !valid, poke ? "R8 start while busy ignored" : "R2 idle after done",
        {busy, sck, valid}, 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!acc_hi && acc_lo && !sck && !busy && !valid && !done,
        "R1 reset state", {acc_hi, acc_lo, sck, busy, valid, done}, 6'b010000);
    run_read(16'h1234, 4, 1'b0);
    run_read(16'hFFFE, 3, 1'b0);
    run_read(16'h00A5, 0, 1'b0);
    stall_mode = 1'b1;
    run_read(16'h8001, 9, 1'b0);
    stall_mode = 1'b0;
    run_read(16'h4321, 3, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule